// File: doc/BRIEF.md
# Pipelined Complex Squarer

This block squares a signed integer complex number a + bi. From the real operand a and the imaginary operand b it forms a real result a*a - b*b and an imaginary result 2*a*b. All values are 32-bit two's-complement integers, and arithmetic wraps modulo 2^32.

An operation is launched by raising `start_i` for one cycle with both operands present. The imaginary result is registered at the first clock edge after launch. The real result is registered at the second edge, and `done_o` marks that result. The pipeline takes a new operation on every cycle. `idle_o` reports that nothing is in flight. Each output holds its value until a later operation overwrites it.

Top module: `cplx_sq`

## Requirements
- R1: After an operation is accepted, `re_o` shows (a*a - b*b) mod 2^32 and `im_o` shows (2*a*b) mod 2^32, both read as signed 32-bit values.
- R2: `im_o` changes at the first rising clock edge after the edge that accepts the operands.
- R3: `re_o` changes at the second rising clock edge after acceptance. `done_o` is high for exactly the one cycle that follows that edge, unless a following operation keeps it high.
- R4: `ready_o` is high in every cycle in which `start_i` is high. An operation is accepted at each rising edge where `start_i` is high, including on consecutive cycles.
- R5: `idle_o` is high exactly when no operation was accepted at either of the last two rising edges.
- R6: While `rst_ni` is low, `re_o` and `im_o` are 0, `done_o` is 0 and `idle_o` is 1.
- R7: When no operation is in flight, both results keep their last values.
- R8: Overflow wraps with no saturation. For example, a = -2^31 and b = 1 give `re_o` = -1 and `im_o` = 0, and a = 65536 with b = 0 gives `re_o` = 0.
- R9: Operands a = 2 and b = 1 give `im_o` = 4 one cycle after acceptance and `re_o` = 3 two cycles after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation this cycle |
| ready_o | output | 1 | Operands are taken at the coming edge |
| done_o | output | 1 | Real result of an operation is valid |
| idle_o | output | 1 | No operation in flight |
| re_i | input | 32 | Real operand a, signed |
| im_i | input | 32 | Imaginary operand b, signed |
| re_o | output | 32 | Real result, signed |
| im_o | output | 32 | Imaginary result, signed |

## Verification
On every cycle, the assertions check these relations between launches and outputs:
- the imaginary value that follows each launch;
- the real value that goes with each done;
- that results hold when there is no launch;
- that `ready_o` goes with `start_i`;
- that idle and done are never high together.

Only the bench scenarios show the reset values, and that the real and imaginary results fall in different cycles during back-to-back bursts. The same is true of the wrap cases at the extreme operands and of the exact 2 + 1i example.

// File: rtl/cplx_sq_pkg.sv
package cplx_sq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LAT    = 2;

  // low DATA_W bits of a signed product
  function automatic logic signed [DATA_W-1:0] mul_lo(
    input logic signed [DATA_W-1:0] x, input logic signed [DATA_W-1:0] y);
    logic signed [DATA_W-1:0] r;
    r = x * y;
    return r;
  endfunction
endpackage

// File: rtl/cplx_sq_ctrl.sv
module cplx_sq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o,
  output logic accept_o,
  output logic stage1_o,
  output logic done_o,
  output logic idle_o
);
  logic v1_q, v2_q;

  assign ready_o  = start_i;
  assign accept_o = start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= accept_o;
      v2_q <= v1_q;
    end
  end

  assign stage1_o = v1_q;
  assign done_o   = v2_q;
  assign idle_o   = ~(v1_q | v2_q);

  // R5
  idle_not_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !done_o);
  // R3
  done_after_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !idle_o);
endmodule

// File: rtl/cplx_sq_mul.sv
module cplx_sq_mul
  import cplx_sq_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                fin_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] re_o,
  output logic signed [W-1:0] im_o
);
  logic signed [W-1:0] aa_q, bb_q, ab;

  assign ab = a_i * b_i;

  // stage 1: squares kept, imaginary result done via shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aa_q <= '0;
      bb_q <= '0;
      im_o <= '0;
    end else if (load_i) begin
      aa_q <= a_i * a_i;
      bb_q <= b_i * b_i;
      im_o <= ab <<< 1;
    end
  end

  // stage 2: real result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) re_o <= '0;
    else if (fin_i) re_o <= aa_q - bb_q;
  end
endmodule

// File: rtl/cplx_sq.sv
module cplx_sq
  import cplx_sq_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logic                     ready_o,
  output logic                     done_o,
  output logic                     idle_o,
  input  logic signed [DATA_W-1:0] re_i,
  input  logic signed [DATA_W-1:0] im_i,
  output logic signed [DATA_W-1:0] re_o,
  output logic signed [DATA_W-1:0] im_o
);
  logic accept, stage1;

  cplx_sq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ready_o (ready_o),
    .accept_o(accept),
    .stage1_o(stage1),
    .done_o  (done_o),
    .idle_o  (idle_o)
  );

  cplx_sq_mul #(.W(DATA_W)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .fin_i (stage1),
    .a_i   (re_i),
    .b_i   (im_i),
    .re_o  (re_o),
    .im_o  (im_o)
  );

  // R2
  im_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> im_o == mul_lo($past(re_i), $past(im_i)) + mul_lo($past(re_i), $past(im_i)));
  // R1
  re_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> re_o == mul_lo($past(re_i, 2), $past(re_i, 2)) - mul_lo($past(im_i, 2), $past(im_i, 2)));
  // R7
  hold_im_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(im_o));
  // R7
  hold_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !start_i) |=> $stable(re_o));
  // R4
  ready_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ready_o);
endmodule

// File: tb/tb_cplx_sq.sv
`timescale 1ns/1ps
module tb_cplx_sq;
  logic clk = 0, rst_ni = 0, start = 0;
  logic ready, done, idle;
  logic signed [31:0] a = 0, b = 0, re, im;
  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cplx_sq dut (.clk_i(clk), .rst_ni(rst_ni), .start_i(start), .ready_o(ready),
               .done_o(done), .idle_o(idle), .re_i(a), .im_i(b), .re_o(re), .im_o(im));

  // behavioural reference
  logic [31:0] m_re = 0, m_im = 0, pend = 0;
  bit m_done = 0, p_valid = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_re = 0; m_im = 0; pend = 0; m_done = 0; p_valid = 0;
    end else begin
      longint la, lb;
      la = a; lb = b;
      m_done = p_valid;
      if (p_valid) m_re = pend;
      if (start) begin
        m_im = 32'(2 * la * lb);
        pend = 32'(la * la - lb * lb);
        p_valid = 1;
      end else p_valid = 0;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle compare, away from the edge
  always @(negedge clk) if (!finished) begin
    chk("R2 im", im, $signed(m_im));
    chk("R3 re", re, $signed(m_re));
    chk("R3 done", done, m_done);
    chk("R5 idle", idle, !p_valid && !m_done);
    chk("R4 ready", ready, start);
  end

  task automatic drive(input bit s, input logic signed [31:0] x, input logic signed [31:0] y);
    @(posedge clk); #1;
    start = s; a = x; b = y;
  endtask

  task automatic summary;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6
    chk("R6 re", re, 0); chk("R6 im", im, 0);
    chk("R6 done", done, 0); chk("R6 idle", idle, 1);
    drive(0, 0, 0); rst_ni = 1;
    // R9 example
    drive(1, 2, 1);
    drive(0, 0, 0);
    @(negedge clk); chk("R9 im", im, 4); chk("R9 re pending", re, 0);
    @(negedge clk); chk("R9 re", re, 3); chk("R9 done", done, 1);
    @(negedge clk); chk("R3 done pulse", done, 0); chk("R5 idle", idle, 1);
    // R7 hold
    repeat (4) @(negedge clk);
    chk("R7 re hold", re, 3); chk("R7 im hold", im, 4);
    // R8 wrap cases
    drive(1, 32'sh8000_0000, 1);
    drive(1, 65536, 0);
    drive(1, -7, 5);
    drive(0, 0, 0);
    @(negedge clk); chk("R1 im -7,5", im, -70);
    @(negedge clk); chk("R1 re -7,5", re, 24);
    @(negedge clk);
    chk("R8 re", re, 24); chk("R7 im", im, -70);
    // R4 back-to-back burst, R1 varied
    for (int i = 0; i < 40; i++)
      drive(1, (i * 32'sd104729) ^ 32'sh5a5a_0f0f, 32'sd3 - i * 32'sd65537);
    for (int i = 0; i < 10; i++) drive(i % 2, i * 3 - 11, 17 - i);
    drive(1, 32'sh7fff_ffff, 32'sh7fff_ffff);
    drive(0, 0, 0);
    repeat (4) @(negedge clk);
    // R1 max: re = 0, im = 2*(2^31-1)^2 mod 2^32 = 2
    chk("R1 max re", re, 0); chk("R1 max im", im, 2);
    summary();
  end

  initial begin
    wait (cyc > 100000);
    failures++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    summary();
  end
endmodule